// File: doc/BRIEF.md
# Clock Mode Decoder and Frame Timing Generator

This block turns a 3-bit clock mode into the internal frame timing of a telecom clock unit. It runs on a fast system clock. A one-cycle pulse, `mst_en`, marks each period of the 16.384 MHz master clock. A frame counter steps once per such pulse and wraps once every 8 kHz frame. From the counter the block derives a 4.096 MHz clock, a 2.048 MHz clock, a one-count FRAME marker and an active-low frame strobe.

The mode controls three things. The first is whether the counter runs freely. The second is whether the counter realigns to the falling edge of an incoming bus frame signal, which happens only in slave mode 4. The third is which source the block names as the reference for the downstream analog PLL. In mode 0 the reference is the external crystal clock after a prescaler, and a crystal-select code picks the prescaler ratio. In mode 4 it is the bus 4 MHz clock. In every other mode it is the digital PLL, fed from one of three 8 kHz inputs. In those digital-PLL modes the frame counter is only frequency locked and is never phase aligned. A master-enable input lets the block drive the bus, except in slave mode, where that input has no effect.

Top module: `clkfrm_gen`

## Requirements
- R1: After reset the counter is 0, so `frame_o`=1, `f0b_o`=0, `clk4_o`=0, `clk2_o`=0, and the prescaler count is 0.
- R2: The counter advances by one on every cycle in which `mst_en`=1 and holds otherwise. It wraps from FRAME_LEN-1 (2047) to 0, and `frame_o` is 1 exactly while the count is 0.
- R3: `clk4_o` equals bit 1 of the count and `clk2_o` equals bit 2. This gives periods of 4 and 8 master-clock enables.
- R4: `f0b_o` is 0 exactly when the count is FRAME_LEN-2, FRAME_LEN-1, 0 or 1. That is one 4.096 MHz period centred on the frame boundary.
- R5: In mode 4, `bus_f0_n` passes through two synchronizer flops, and a falling edge is seen at the output of the second one. The counter then loads 0 at the first `mst_en` edge at or after the detection. With `mst_en` held at 1, a low driven just before clock edge P1 gives count 0 after edge P3.
- R6: Outside mode 4, `bus_f0_n` has no effect on the counter. A request still pending is dropped when the mode leaves 4.
- R7: `ref_sel_o` is 0 (crystal) in mode 0, 1 (bus clock) in mode 4 and 2 (digital PLL) in modes 1-3 and 5-7. `dpll_src_o` is mode[1:0] in the digital-PLL modes and 0 otherwise.
- R8: The prescaler counts `xclk_tick` pulses. In mode 0, a `xtal_sel` value of 0 gives a ratio of 4, 1 gives 2, 2 gives 1 and 3 gives 4. Every other mode uses a ratio of 4. `xref_tick_o` is 1 when `xclk_tick`=1 and the count is at least ratio-1, and the count then returns to 0.
- R9: `bus_drive_o` is 1 only when `master_en`=1 and the mode is not 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_en | input | 1 | One pulse per 16.384 MHz master-clock period |
| xclk_tick | input | 1 | One pulse per external crystal clock period |
| mode | input | 3 | Clock mode, 0 to 7 |
| xtal_sel | input | 2 | Crystal frequency code, used in mode 0 |
| master_en | input | 1 | Request to drive bus timing |
| bus_f0_n | input | 1 | Incoming active-low bus frame pulse (asynchronous) |
| clk4_o | output | 1 | 4.096 MHz clock |
| clk2_o | output | 1 | 2.048 MHz clock |
| frame_o | output | 1 | Frame marker, high at count 0 |
| f0b_o | output | 1 | Active-low frame strobe |
| bus_drive_o | output | 1 | Enable for the bus output drivers |
| ref_sel_o | output | 2 | Analog PLL reference choice |
| dpll_src_o | output | 2 | Digital PLL 8 kHz source (1-3, 0 = unused) |
| xref_tick_o | output | 1 | Prescaled crystal reference pulse |

## Verification
The assertions check four rules on every cycle. The counter holds without an enable and steps by exactly one outside slave mode. The 2.048 MHz clock changes only after an enable. The strobe is low whenever FRAME is high. The assertions also check that slave mode never drives the bus, that the digital-PLL modes always name a source, and that a prescaled pulse never appears without an input tick. Only the bench's scenarios can show the rest. That covers the exact three-edge realignment latency in mode 4, the full 2048-enable frame period with and without bus pulses present, and the prescaler ratios across crystal codes and mode changes.

// File: rtl/clkfrm_pkg.sv
package clkfrm_pkg;
   typedef enum logic [1:0] {
      REF_XTAL = 2'd0,
      REF_BUS  = 2'd1,
      REF_DPLL = 2'd2
   } ref_sel_e;

   localparam logic [2:0] MODE_MASTER = 3'd0;
   localparam logic [2:0] MODE_SLAVE  = 3'd4;

   // prescale ratio for the crystal path; only mode 0 honours the code
   function automatic logic [2:0] xtal_ratio(input logic [2:0] mode, input logic [1:0] sel);
      if (mode != MODE_MASTER) return 3'd4;
      case (sel)
         2'd1:    return 3'd2;
         2'd2:    return 3'd1;
         default: return 3'd4;
      endcase
   endfunction
endpackage

// File: rtl/clkfrm_mode_dec.sv
module clkfrm_mode_dec
   import clkfrm_pkg::*;
(
   input  logic [2:0] mode,
   input  logic       master_en,
   output ref_sel_e   ref_sel,
   output logic [1:0] dpll_src,
   output logic       slave,
   output logic       drive
);
   always_comb begin
      slave = (mode == MODE_SLAVE);
      if (mode == MODE_MASTER)
         ref_sel = REF_XTAL;
      else if (slave)
         ref_sel = REF_BUS;
      else
         ref_sel = REF_DPLL;
      dpll_src = (ref_sel == REF_DPLL) ? mode[1:0] : 2'd0;
      drive    = master_en & ~slave;
   end
endmodule

// File: rtl/clkfrm_prescale.sv
module clkfrm_prescale #(
   parameter int MAX_DIV = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       xclk_tick,
   input  logic [2:0] ratio,
   output logic       tick_o
);
   localparam int PRE_W = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

   if (MAX_DIV < 4 || MAX_DIV > 7) begin : g_bad_div
      $error("clkfrm_prescale: MAX_DIV must lie in 4..7");
   end

   logic [PRE_W-1:0] pc;
   logic             wrap;

   assign wrap   = (3'(pc) >= (ratio - 3'd1));
   assign tick_o = xclk_tick & wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc <= '0;
      else if (xclk_tick)
         pc <= wrap ? '0 : pc + 1'b1;
   end
endmodule

// File: rtl/clkfrm_bus_sync.sv
module clkfrm_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic f0_n_i,
   output logic fall_o
);
   if (STAGES < 1) begin : g_bad_stages
      $error("clkfrm_bus_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] sh;
   logic              prev;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '1;
         else        sh <= f0_n_i;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '1;
         else        sh <= {sh[STAGES-2:0], f0_n_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= sh[STAGES-1];
   end

   assign fall_o = prev & ~sh[STAGES-1];
endmodule

// File: rtl/clkfrm_counter.sv
module clkfrm_counter #(
   parameter int FRAME_LEN = 2048
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         mst_en,
   input  logic                         slave,
   input  logic                         sync_req,
   output logic [$clog2(FRAME_LEN)-1:0] cnt,
   output logic                         clk4,
   output logic                         clk2,
   output logic                         frame,
   output logic                         f0b
);
   localparam int CNT_W = $clog2(FRAME_LEN);
   localparam logic [CNT_W-1:0] EDGE_LO = CNT_W'(FRAME_LEN - 2);

   if (FRAME_LEN < 16 || (FRAME_LEN & (FRAME_LEN - 1)) != 0) begin : g_bad_len
      $error("clkfrm_counter: FRAME_LEN must be a power of two, at least 16");
   end

   logic pend;
   logic want;
   logic load;

   assign want = slave & (pend | sync_req);
   assign load = want & mst_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         pend <= 1'b0;
      end else begin
         pend <= want & ~mst_en;
         if (load)
            cnt <= '0;
         else if (mst_en)
            cnt <= cnt + 1'b1;
      end
   end

   assign clk4  = cnt[1];
   assign clk2  = cnt[2];
   assign frame = (cnt == '0);
   assign f0b   = ~((cnt >= EDGE_LO) || (cnt <= CNT_W'(1)));
endmodule

// File: rtl/clkfrm_gen.sv
module clkfrm_gen
   import clkfrm_pkg::*;
#(
   parameter int FRAME_LEN   = 2048,
   parameter int SYNC_STAGES = 2,
   parameter int MAX_DIV     = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mst_en,
   input  logic       xclk_tick,
   input  logic [2:0] mode,
   input  logic [1:0] xtal_sel,
   input  logic       master_en,
   input  logic       bus_f0_n,
   output logic       clk4_o,
   output logic       clk2_o,
   output logic       frame_o,
   output logic       f0b_o,
   output logic       bus_drive_o,
   output logic [1:0] ref_sel_o,
   output logic [1:0] dpll_src_o,
   output logic       xref_tick_o
);
   localparam int CNT_W = $clog2(FRAME_LEN);

   ref_sel_e         ref_sel;
   logic             slave;
   logic             bus_fall;
   logic [CNT_W-1:0] cnt;

   clkfrm_mode_dec u_dec (
      .mode      (mode),
      .master_en (master_en),
      .ref_sel   (ref_sel),
      .dpll_src  (dpll_src_o),
      .slave     (slave),
      .drive     (bus_drive_o)
   );

   clkfrm_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .f0_n_i (bus_f0_n),
      .fall_o (bus_fall)
   );

   clkfrm_counter #(.FRAME_LEN(FRAME_LEN)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .mst_en   (mst_en),
      .slave    (slave),
      .sync_req (bus_fall),
      .cnt      (cnt),
      .clk4     (clk4_o),
      .clk2     (clk2_o),
      .frame    (frame_o),
      .f0b      (f0b_o)
   );

   clkfrm_prescale #(.MAX_DIV(MAX_DIV)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .xclk_tick (xclk_tick),
      .ratio     (xtal_ratio(mode, xtal_sel)),
      .tick_o    (xref_tick_o)
   );

   assign ref_sel_o = ref_sel;
endmodule

// File: rtl/clkfrm_gen_chk.sv
module clkfrm_gen_chk #(
   parameter int CNT_W = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mst_en,
   input logic             xclk_tick,
   input logic [2:0]       mode,
   input logic [CNT_W-1:0] cnt,
   input logic             frame_o,
   input logic             f0b_o,
   input logic             clk2_o,
   input logic             bus_drive_o,
   input logic [1:0]       dpll_src_o,
   input logic             xref_tick_o
);
   p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mst_en |=> cnt == $past(cnt));

   p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_en && mode != 3'd4) |=> cnt == $past(cnt) + CNT_W'(1));

   p_clk2_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(clk2_o) |-> $past(mst_en));

   p_frame_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_o |-> !f0b_o);

   p_slave_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd4) |-> !bus_drive_o);

   p_dpll_named_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 3'd0 && mode != 3'd4) |-> dpll_src_o != 2'd0);

   p_xref_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xref_tick_o |-> xclk_tick);
endmodule

bind clkfrm_gen clkfrm_gen_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mst_en      (mst_en),
   .xclk_tick   (xclk_tick),
   .mode        (mode),
   .cnt         (cnt),
   .frame_o     (frame_o),
   .f0b_o       (f0b_o),
   .clk2_o      (clk2_o),
   .bus_drive_o (bus_drive_o),
   .dpll_src_o  (dpll_src_o),
   .xref_tick_o (xref_tick_o)
);

// File: tb/clkfrm_gen_tb.sv
`timescale 1ns/1ps
module clkfrm_gen_tb;
   localparam int FLEN = 2048;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mst_en = 1'b0;
   logic       xclk_tick = 1'b0;
   logic [2:0] mode = 3'd0;
   logic [1:0] xtal_sel = 2'd0;
   logic       master_en = 1'b0;
   logic       bus_f0_n = 1'b1;
   logic       clk4_o, clk2_o, frame_o, f0b_o, bus_drive_o, xref_tick_o;
   logic [1:0] ref_sel_o, dpll_src_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   clkfrm_gen u_dut (
      .clk(clk), .rst_n(rst_n), .mst_en(mst_en), .xclk_tick(xclk_tick),
      .mode(mode), .xtal_sel(xtal_sel), .master_en(master_en), .bus_f0_n(bus_f0_n),
      .clk4_o(clk4_o), .clk2_o(clk2_o), .frame_o(frame_o), .f0b_o(f0b_o),
      .bus_drive_o(bus_drive_o), .ref_sel_o(ref_sel_o), .dpll_src_o(dpll_src_o),
      .xref_tick_o(xref_tick_o)
   );

   always #2.5 clk = ~clk;

   // reference model built from the requirements
   logic        m_s0, m_s1, m_prev, m_pend;
   logic [10:0] m_cnt;
   logic [1:0]  m_pc;

   function automatic logic [2:0] f_ratio(input logic [2:0] md, input logic [1:0] xs);
      if (md != 3'd0) return 3'd4;
      if (xs == 2'd1) return 3'd2;
      if (xs == 2'd2) return 3'd1;
      return 3'd4;
   endfunction

   function automatic logic f_f0b(input logic [10:0] c);
      return !((c >= 11'(FLEN - 2)) || (c <= 11'd1));
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s0 <= 1'b1; m_s1 <= 1'b1; m_prev <= 1'b1;
         m_pend <= 1'b0; m_cnt <= '0; m_pc <= '0;
      end else begin
         logic sl, rq, ld, wr;
         sl = (mode == 3'd4);
         rq = sl && m_prev && !m_s1;
         ld = sl && mst_en && (m_pend || rq);
         m_pend <= sl && (m_pend || rq) && !mst_en;
         m_s0 <= bus_f0_n; m_s1 <= m_s0; m_prev <= m_s1;
         if (ld) m_cnt <= '0;
         else if (mst_en) m_cnt <= m_cnt + 11'd1;
         wr = (3'(m_pc) >= f_ratio(mode, xtal_sel) - 3'd1);
         if (xclk_tick) m_pc <= wr ? 2'd0 : m_pc + 2'd1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
      n_chk++;
      if (act !== exp_v) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp_v, $time);
      end
   endtask

   task automatic check_all();
      logic [1:0] er;
      er = (mode == 3'd0) ? 2'd0 : (mode == 3'd4) ? 2'd1 : 2'd2;
      chk("R2 frame",  32'(frame_o), 32'(m_cnt == 11'd0));
      chk("R3 clk4",   32'(clk4_o),  32'(m_cnt[1]));
      chk("R3 clk2",   32'(clk2_o),  32'(m_cnt[2]));
      chk("R4 f0b",    32'(f0b_o),   32'(f_f0b(m_cnt)));
      chk("R7 ref",    32'(ref_sel_o), 32'(er));
      chk("R7 dpll",   32'(dpll_src_o), 32'((er == 2'd2) ? mode[1:0] : 2'd0));
      chk("R8 xref",   32'(xref_tick_o),
          32'(xclk_tick && (3'(m_pc) >= f_ratio(mode, xtal_sel) - 3'd1)));
      chk("R9 drive",  32'(bus_drive_o), 32'(master_en && mode != 3'd4));
   endtask

   // measure enables between two frame markers with mst_en held high
   task automatic frame_period(input string tag, input bit pulses);
      int gap;
      mst_en = 1'b1;
      while (!frame_o) begin
         @(negedge clk);
         check_all();
      end
      gap = 0;
      do begin
         @(negedge clk);
         check_all();
         gap++;
         bus_f0_n = pulses ? (($urandom % 30) != 0) : 1'b1;
      end while (!frame_o);
      bus_f0_n = 1'b1;
      chk(tag, 32'(gap), 32'(FLEN));
   endtask

   initial begin
      void'($urandom(32'h5eed));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 frame", 32'(frame_o), 32'd1);
      chk("R1 f0b",   32'(f0b_o),   32'd0);
      chk("R1 clk4",  32'(clk4_o),  32'd0);
      chk("R1 clk2",  32'(clk2_o),  32'd0);
      chk("R1 xref",  32'(xref_tick_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: free-running frame period in mode 0
      mode = 3'd0;
      frame_period("R2 period", 1'b0);

      // R6: bus pulses ignored in a digital-PLL mode
      mode = 3'd2;
      frame_period("R6 period", 1'b1);

      // R5: realignment latency in slave mode
      mode = 3'd4; mst_en = 1'b1;
      while (!(m_cnt > 11'd10 && m_cnt < 11'd1000)) begin
         @(negedge clk);
         check_all();
      end
      bus_f0_n = 1'b0;
      @(negedge clk); check_all();
      @(negedge clk); check_all();
      chk("R5 before", 32'(frame_o), 32'd0);
      @(negedge clk); check_all();
      chk("R5 aligned", 32'(frame_o), 32'd1);
      bus_f0_n = 1'b1;

      // R8: each crystal code in mode 0 with a tick every cycle
      mode = 3'd0; xclk_tick = 1'b1;
      for (int s = 0; s < 4; s++) begin
         int hits;
         xtal_sel = 2'(s);
         repeat (8) @(negedge clk);
         hits = 0;
         for (int k = 0; k < 8; k++) begin
            check_all();
            if (xref_tick_o) hits++;
            @(negedge clk);
         end
         chk("R8 ratio", 32'(hits), 32'(8 / f_ratio(3'd0, 2'(s))));
      end

      // constrained random mix
      for (int i = 0; i < 24000; i++) begin
         @(negedge clk);
         check_all();
         mst_en    = ($urandom % 4) != 0;
         xclk_tick = ($urandom % 3) != 0;
         master_en = ($urandom % 2) != 0;
         if (($urandom % 64) == 0) mode = ($urandom % 3 == 0) ? 3'd4 : 3'($urandom);
         if (($urandom % 50) == 0) xtal_sel = 2'($urandom);
         bus_f0_n = ($urandom % 25) != 0;
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule